// File: doc/BRIEF.md
# Signed ALU with Three-Flag Condition Register

This block is the execute stage arithmetic core of a small teaching processor. Each cycle it combines two 32-bit register operands, one read from the source register field and one from the destination register field, under a 4-bit operation selector. The supported operations are add, subtract, bitwise AND and bitwise XOR. Subtraction takes the source operand away from the destination operand, because the result is written back over the destination register. The result is combinational.

When the decode stage marks an instruction as arithmetic or logical, the block captures three flags into a register at the clock edge: signed overflow, zero and negative. There is no carry flag, and every comparison is a signed two's complement comparison. Move, load and store instructions leave the update enable low, so the flags keep the value set by the most recent arithmetic or logical instruction. A branch evaluator reads the registered flags and a 4-bit condition selector, and raises a take-branch output for an unconditional jump or for one of six signed comparisons.

Unused operation codes and unused condition codes are reported on an invalid-function output. They never change the flags.

Top module: `cc_alu`

## Requirements
- R1: Operation code 0 gives `opb + opa` and code 1 gives `opb - opa`, both modulo 2^32, with no wait state.
- R2: Operation code 2 gives `opb & opa` and code 3 gives `opb ^ opa`, with no wait state.
- R3: While `cc_we` is low the three flag outputs hold their values, whatever the operation and operands are.
- R4: A clock edge with `cc_we` high and a valid operation code loads `flag_zf` with (result == 0) and `flag_sf` with result bit 31.
- R5: A flag update caused by operation code 2 or 3 clears `flag_of`.
- R6: A flag update caused by add sets `flag_of` exactly when both operands have the same sign and the sum's sign differs from it.
- R7: A flag update caused by subtract sets `flag_of` exactly when the operands differ in sign and the difference's sign differs from `opb`.
- R8: `take_br` is combinational from the registered flags. Condition code 0 is always taken, 1 is taken on (SF^OF)|ZF, 2 on SF^OF, 3 on ZF, 4 on !ZF, 5 on SF==OF, and 6 on (SF==OF)&!ZF.
- R9: An operation code above 3 gives result 0 and raises `bad_fn`, and it leaves the flags unchanged even when `cc_we` is high.
- R10: A condition code above 6 forces `take_br` low and raises `bad_fn`.
- R11: Reset (`rst_n` low, asynchronous) sets ZF=1, SF=0 and OF=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 32 | Source register operand |
| opb | input | 32 | Destination register operand |
| alu_fn | input | 4 | Operation code |
| cc_we | input | 1 | Flag register update enable |
| br_fn | input | 4 | Branch condition code |
| result | output | 32 | Operation result |
| flag_of | output | 1 | Registered signed overflow flag |
| flag_zf | output | 1 | Registered zero flag |
| flag_sf | output | 1 | Registered negative flag |
| take_br | output | 1 | Branch condition met |
| bad_fn | output | 1 | Operation or condition code out of range |

## Verification
The hardest cases to reach are the flag states in which the signed comparisons disagree with a plain sign test. These states need OF=1 together with either value of SF, and with ZF clear. Uniform random operands almost never produce a signed overflow on subtract at the exact boundaries. The stimulus therefore draws operands from a pool biased toward 0x7FFFFFFF, 0x80000000, 0, 1 and -1. Directed overflowing add and subtract cases are also mixed in, and every one of the seven conditions is evaluated against each flag state that results.

// File: rtl/cc_alu.sv
module cc_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   alu_fn,
  input  logic         cc_we,
  input  logic [3:0]   br_fn,
  output logic [W-1:0] result,
  output logic         flag_of,
  output logic         flag_zf,
  output logic         flag_sf,
  output logic         take_br,
  output logic         bad_fn
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_XOR = 4'd3;

  logic [W-1:0] sum, dif;
  logic add_ovf, sub_ovf, ovf_n, alu_bad, br_bad, sgn_lt;

  assign sum = opb + opa;
  assign dif = opb - opa;
  assign add_ovf = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
  assign sub_ovf = (opa[MSB] != opb[MSB]) && (dif[MSB] != opb[MSB]);
  assign alu_bad = alu_fn > OP_XOR;
  assign br_bad  = br_fn > 4'd6;
  assign bad_fn  = alu_bad | br_bad;

  always_comb begin
    result = '0;
    ovf_n  = 1'b0;
    case (alu_fn)
      OP_ADD: begin result = sum; ovf_n = add_ovf; end
      OP_SUB: begin result = dif; ovf_n = sub_ovf; end
      OP_AND: result = opb & opa;
      OP_XOR: result = opb ^ opa;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_of <= 1'b0;
      flag_zf <= 1'b1;
      flag_sf <= 1'b0;
    end else if (cc_we && !alu_bad) begin
      flag_of <= ovf_n;
      flag_zf <= (result == '0);
      flag_sf <= result[MSB];
    end
  end

  assign sgn_lt = flag_sf ^ flag_of;

  always_comb begin
    case (br_fn)
      4'd0: take_br = 1'b1;
      4'd1: take_br = sgn_lt | flag_zf;
      4'd2: take_br = sgn_lt;
      4'd3: take_br = flag_zf;
      4'd4: take_br = !flag_zf;
      4'd5: take_br = !sgn_lt;
      4'd6: take_br = !sgn_lt && !flag_zf;
      default: take_br = 1'b0;
    endcase
  end

  a_r3_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_we |=> $stable({flag_of, flag_zf, flag_sf}));

  a_r4_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && alu_fn <= OP_XOR) |=>
      (flag_zf == ($past(result) == '0)) && (flag_sf == $past(result[MSB])));

  a_r5_logic_clears_of: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && (alu_fn == OP_AND || alu_fn == OP_XOR)) |=> !flag_of);

  a_r6_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && alu_fn == OP_ADD) |=>
      flag_of == (($past(opa[MSB]) == $past(opb[MSB])) && ($past(result[MSB]) != $past(opb[MSB]))));

  a_r7_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && alu_fn == OP_SUB) |=>
      flag_of == (($past(opa[MSB]) != $past(opb[MSB])) && ($past(result[MSB]) != $past(opb[MSB]))));

  a_r8_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fn == 4'd3) |-> (take_br == flag_zf));

  a_r8_greater: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fn == 4'd6 && take_br) |-> (!flag_zf && flag_sf == flag_of));

  a_r9_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn > OP_XOR) |-> (result == '0 && bad_fn));

  a_r9_bad_op_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn > OP_XOR) |=> $stable({flag_of, flag_zf, flag_sf}));

  a_r10_bad_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fn > 4'd6) |-> (!take_br && bad_fn));
endmodule

// File: tb/tb_cc_alu.sv
module tb_cc_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0] alu_fn = '0, br_fn = '0;
  logic cc_we = 1'b0;
  logic [31:0] result;
  logic flag_of, flag_zf, flag_sf, take_br, bad_fn;

  int n_chk = 0, n_bad = 0;
  logic m_of = 1'b0, m_zf = 1'b1, m_sf = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cc_alu dut (.clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .alu_fn(alu_fn),
              .cc_we(cc_we), .br_fn(br_fn), .result(result), .flag_of(flag_of),
              .flag_zf(flag_zf), .flag_sf(flag_sf), .take_br(take_br), .bad_fn(bad_fn));

  function automatic logic [31:0] f_res(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      4'd0: return b + a;
      4'd1: return b - a;
      4'd2: return b & a;
      4'd3: return b ^ a;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic f_ovf(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (f == 4'd0) r = sb + sa;
    else if (f == 4'd1) r = sb - sa;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic logic f_take(input logic [3:0] c, input logic o, input logic z, input logic s);
    case (c)
      4'd0: return 1'b1;
      4'd1: return (s != o) || z;
      4'd2: return s != o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return s == o;
      4'd6: return (s == o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] f);
    if (f < 4'd2) return "R1";
    if (f < 4'd4) return "R2";
    return "R9";
  endfunction

  task automatic step(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                      input logic we, input logic [3:0] c);
    logic ex_of, ex_zf, ex_sf;
    @(negedge clk);
    alu_fn = f; opa = a; opb = b; cc_we = we; br_fn = c;
    #1;
    chk(tag_of(f), result, f_res(f, a, b));
    chk((c > 4'd6) ? "R10" : "R8", {31'd0, take_br}, {31'd0, f_take(c, m_of, m_zf, m_sf)});
    chk((f > 4'd3) ? "R9" : "R10", {31'd0, bad_fn}, {31'd0, (f > 4'd3) || (c > 4'd6)});
    if (we && f <= 4'd3) begin
      ex_of = f_ovf(f, a, b);
      ex_zf = (f_res(f, a, b) == 32'd0);
      ex_sf = f_res(f, a, b) >> 31;
    end else begin
      ex_of = m_of; ex_zf = m_zf; ex_sf = m_sf;
    end
    @(negedge clk);
    #1;
    chk(!we ? "R3" : (f > 4'd3) ? "R9" : (f == 4'd0) ? "R6" : (f == 4'd1) ? "R7" : "R5",
        {31'd0, flag_of}, {31'd0, ex_of});
    chk(!we ? "R3" : (f > 4'd3) ? "R9" : "R4", {30'd0, flag_zf, flag_sf}, {30'd0, ex_zf, ex_sf});
    m_of = ex_of; m_zf = ex_zf; m_sf = ex_sf;
  endtask

  function automatic logic [31:0] pick(input int unsigned r);
    case (r % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'd0;
      3: return 32'd1;
      4: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #9;
    chk("R11", {29'd0, flag_of, flag_zf, flag_sf}, 32'b010);
    br_fn = 4'd3; #1;
    chk("R11", {31'd0, take_br}, 32'd1);
    rst_n = 1'b1;
    step(4'd0, 32'd1, 32'h7FFF_FFFF, 1'b1, 4'd2);
    step(4'd1, 32'd1, 32'h8000_0000, 1'b1, 4'd2);
    step(4'd1, 32'h8000_0000, 32'd0, 1'b1, 4'd1);
    step(4'd1, 32'd5, 32'd5, 1'b1, 4'd6);
    step(4'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1, 4'd3);
    step(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 4'd4);
    step(4'd2, 32'hF000_0000, 32'hFFFF_0000, 1'b1, 4'd5);
    step(4'd0, 32'd3, 32'd4, 1'b0, 4'd2);
    step(4'd7, 32'd3, 32'd4, 1'b1, 4'd7);
    step(4'd15, 32'hFFFF_FFFF, 32'd0, 1'b1, 4'd15);
    for (int i = 0; i < 600; i++) begin
      step(4'($urandom % 5), pick($urandom), pick($urandom), ($urandom % 4) != 0,
           4'($urandom % 8));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule